// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Two Compare Channels

This block is an 8-bit timer/counter that software drives through a small register file. A clock-select field picks what advances the count: every clock, one of four prescaler taps supplied from outside, or a synchronised rising or falling edge of an external pin. A zero in that field stops the count. A waveform-mode field picks one of four counting sequences. The count unit reports when the count sits at its maximum or at zero, and it raises an overflow event at a point that depends on the sequence.

Two compare channels watch the count against their own compare registers. Each channel sets a flag when the count matches, and it drives an output pin that is toggled, cleared or set on a match. In the two pulse-width modes that pin is also restored at the wrap point or at the bottom. Three sticky flags (overflow, compare A, compare B) each raise an interrupt request when enabled. Software clears a flag by writing a one to it, and the interrupt controller clears it with an acknowledge pulse.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: The clock-select field CTRLB[2:0] is decoded as follows. 0 stops the count. 1 advances it on every clock. 2, 3, 4 and 5 advance it on a cycle where presc_tick bit 0, 1, 2 or 3 is high.
- R2: Clock-select 6 advances the count once per falling edge of ext_pin and 7 once per rising edge, each after a two-stage synchroniser.
- R3: A write to the count register (address 2) loads the written value and takes the place of any step in that cycle. That cycle counts as no tick for overflow, compare flags or outputs. The count can be read at any time.
- R4: Wave code 000 counts up and wraps from 0xFF to 0, setting overflow on the tick taken from 0xFF. Codes 100 to 111 behave the same way. The wave code is {CTRLB[3], CTRLA[1:0]}.
- R5: Wave code 010 clears the count to 0 on a tick taken while the count equals compare A, and otherwise counts up. Overflow is set on a tick taken from 0xFF.
- R6: Wave code 011 counts up and wraps from 0xFF to 0, setting overflow on the tick taken from 0xFF.
- R7: Wave code 001 counts up to 0xFF, then down to 0, then up again, so the count runs 0, 1, ... 0xFF, 0xFE, ... 1, 0, 1. Overflow is set on every tick taken while the count is 0.
- R8: at_top is high exactly while the count is 0xFF and at_bottom exactly while it is 0.
- R9: A tick taken while the count equals compare A (address 3) or compare B (address 4) sets flag bit 1 or bit 2. A flag set in a cycle wins over a clear in the same cycle.
- R10: Flags live at address 5 as bit 0 overflow, bit 1 compare A and bit 2 compare B. Writing a one to a bit clears it, writing a zero leaves it alone, and a high irq_ack bit clears the same flag.
- R11: irq[i] is flag bit i AND enable bit i of the enable register (address 6).
- R12: The output mode of channel A is CTRLA[3:2] and of channel B is CTRLA[5:4]. 00 holds the output low. On a matching tick, 01 toggles it, 10 clears it and 11 sets it. In wave code 011, a tick from 0xFF first sets the output (mode 10) or clears it (mode 11). In wave code 001 the same happens on a tick from 0. A match in the same tick overrides this restore.
- R13: The register map is 0 CTRLA, 1 CTRLB, 2 count, 3 compare A, 4 compare B, 5 flags, 6 interrupt enable, and 7 reads as zero. After reset every register reads 0 and every output is low except at_bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered from bus_addr |
| presc_tick | input | 4 | Prescaler tap pulses |
| ext_pin | input | 1 | External count input, asynchronous |
| irq_ack | input | 3 | Per-flag interrupt acknowledge |
| irq | output | 3 | Interrupt requests: overflow, compare A, compare B |
| oc_a | output | 1 | Channel A compare output |
| oc_b | output | 1 | Channel B compare output |
| at_top | output | 1 | Count equals 0xFF |
| at_bottom | output | 1 | Count equals 0 |

## Verification
A tick or a write given in one cycle is in the count, the flags, irq, oc_a, oc_b, at_top and at_bottom at the next clock edge. bus_rdata shows the register addressed at an edge as it stood before that edge. An external pin edge turns into a tick on the third clock edge after the pin changes. The bench drives inputs and samples outputs on the falling clock edge. In the random runs it compares bus_rdata against the model count from before the last edge, and it compares the other outputs against the model after the edge. The directed tests leave several idle cycles after each external pin change before they read the count.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int PRESC_TAPS = 4;

  localparam logic [2:0] ADR_CTRLA = 3'd0;
  localparam logic [2:0] ADR_CTRLB = 3'd1;
  localparam logic [2:0] ADR_COUNT = 3'd2;
  localparam logic [2:0] ADR_CMPA  = 3'd3;
  localparam logic [2:0] ADR_CMPB  = 3'd4;
  localparam logic [2:0] ADR_FLAGS = 3'd5;
  localparam logic [2:0] ADR_IRQEN = 3'd6;

  typedef enum logic [1:0] {
    SEQ_WRAP      = 2'd0,
    SEQ_CLR_MATCH = 2'd1,
    SEQ_FAST      = 2'd2,
    SEQ_PHASE     = 2'd3
  } seq_e;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_CLEAR  = 2'd2,
    OUT_SET    = 2'd3
  } outm_e;

  function automatic seq_e decode_seq(input logic [2:0] wave);
    case (wave)
      3'b001:  return SEQ_PHASE;
      3'b010:  return SEQ_CLR_MATCH;
      3'b011:  return SEQ_FAST;
      default: return SEQ_WRAP;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_tick_sel.sv
module tmr8_tick_sel
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            clk_sel,
  input  logic [PRESC_TAPS-1:0] presc_tick,
  input  logic                  ext_pin,
  output logic                  tick
);
  localparam int TAP_W = $clog2(PRESC_TAPS);

  // synchroniser stages plus one history stage for edge detection
  logic [SYNC_STAGES:0] pin_sh;
  logic                 pin_rise, pin_fall;
  logic [2:0]           tap_sel;

  always_ff @(posedge clk) begin
    if (rst) pin_sh <= '0;
    else     pin_sh <= {pin_sh[SYNC_STAGES-1:0], ext_pin};
  end

  assign pin_rise = pin_sh[SYNC_STAGES-1] & ~pin_sh[SYNC_STAGES];
  assign pin_fall = ~pin_sh[SYNC_STAGES-1] & pin_sh[SYNC_STAGES];
  assign tap_sel  = clk_sel - 3'd2;

  always_comb begin
    case (clk_sel)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd6:    tick = pin_fall;
      3'd7:    tick = pin_rise;
      default: tick = presc_tick[tap_sel[TAP_W-1:0]];
    endcase
  end
endmodule

// File: rtl/tmr8_count_unit.sv
module tmr8_count_unit
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  seq_e         seq,
  input  logic [W-1:0] cmp_a,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         at_bottom,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic         down_q, down_n, turn_down;
  logic [W-1:0] cnt_n;

  assign at_top    = (cnt == MAX);
  assign at_bottom = (cnt == '0);

  always_comb begin
    cnt_n     = cnt;
    down_n    = down_q;
    ovf_evt   = 1'b0;
    turn_down = down_q;
    if (wr) begin
      cnt_n = wr_data;
    end else if (step) begin
      case (seq)
        SEQ_CLR_MATCH: begin
          cnt_n   = (cnt == cmp_a) ? '0 : cnt + ONE;
          ovf_evt = at_top;
        end
        SEQ_PHASE: begin
          if (at_top)         turn_down = 1'b1;
          else if (at_bottom) turn_down = 1'b0;
          cnt_n   = turn_down ? cnt - ONE : cnt + ONE;
          down_n  = turn_down;
          ovf_evt = at_bottom;
        end
        default: begin
          cnt_n   = cnt + ONE;
          ovf_evt = at_top;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      down_q <= down_n;
    end
  end
endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  seq_e         seq,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   out_mode,
  output logic         match_evt,
  output logic         oc
);
  localparam logic [W-1:0] MAX = '1;

  outm_e om;
  logic  reinit;
  logic  oc_n;

  assign om        = outm_e'(out_mode);
  assign match_evt = step && (cnt == cmp);
  assign reinit    = step && (((seq == SEQ_FAST) && (cnt == MAX)) ||
                              ((seq == SEQ_PHASE) && (cnt == '0)));

  always_comb begin
    oc_n = oc;
    if (om == OUT_OFF) begin
      oc_n = 1'b0;
    end else begin
      if (reinit) begin
        if (om == OUT_CLEAR)    oc_n = 1'b1;
        else if (om == OUT_SET) oc_n = 1'b0;
      end
      if (match_evt) begin
        case (om)
          OUT_TOGGLE: oc_n = ~oc_n;
          OUT_CLEAR:  oc_n = 1'b0;
          default:    oc_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oc <= 1'b0;
    else     oc <= oc_n;
  end
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
  import tmr8_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            bus_addr,
  input  logic                  bus_we,
  input  logic [W-1:0]          bus_wdata,
  output logic [W-1:0]          bus_rdata,
  input  logic [PRESC_TAPS-1:0] presc_tick,
  input  logic                  ext_pin,
  input  logic [2:0]            irq_ack,
  output logic [2:0]            irq,
  output logic                  oc_a,
  output logic                  oc_b,
  output logic                  at_top,
  output logic                  at_bottom
);
  localparam int NCH = 2;

  logic [5:0]   ctrla_q;
  logic [3:0]   ctrlb_q;
  logic [W-1:0] cmp_q [NCH];
  logic [2:0]   flags_q, irqen_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cmp_a_val;
  logic [2:0]   clk_sel;
  seq_e         seq;
  logic         tick, step, cnt_wr, flags_wr, ovf_evt;
  logic [NCH-1:0] match, oc_vec;
  logic [2:0]   flag_set, flag_clr;

  assign clk_sel   = ctrlb_q[2:0];
  assign seq       = decode_seq({ctrlb_q[3], ctrla_q[1:0]});
  assign cnt_wr    = bus_we && (bus_addr == ADR_COUNT);
  assign flags_wr  = bus_we && (bus_addr == ADR_FLAGS);
  assign step      = tick && !cnt_wr;
  assign cmp_a_val = cmp_q[0];

  tmr8_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .presc_tick(presc_tick),
    .ext_pin(ext_pin), .tick(tick)
  );

  tmr8_count_unit #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .wr(cnt_wr), .wr_data(bus_wdata),
    .seq(seq), .cmp_a(cmp_a_val), .cnt(cnt_q), .at_top(at_top),
    .at_bottom(at_bottom), .ovf_evt(ovf_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr8_cmp_chan #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .step(step), .seq(seq), .cnt(cnt_q),
      .cmp(cmp_q[g]), .out_mode(ctrla_q[2+2*g +: 2]),
      .match_evt(match[g]), .oc(oc_vec[g])
    );
  end

  assign oc_a = oc_vec[0];
  assign oc_b = oc_vec[1];

  // control and compare registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrla_q <= '0;
      ctrlb_q <= '0;
      irqen_q <= '0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADR_CTRLA) ctrla_q <= bus_wdata[5:0];
      if (bus_addr == ADR_CTRLB) ctrlb_q <= bus_wdata[3:0];
      if (bus_addr == ADR_IRQEN) irqen_q <= bus_wdata[2:0];
      for (int i = 0; i < NCH; i++)
        if (bus_addr == ADR_CMPA + 3'(i)) cmp_q[i] <= bus_wdata;
    end
  end

  // sticky flags: a set in the same cycle wins over any clear
  assign flag_set = {match[1], match[0], ovf_evt};
  assign flag_clr = irq_ack | (flags_wr ? bus_wdata[2:0] : 3'b000);

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = flags_q & irqen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADR_CTRLA: bus_rdata <= W'(ctrla_q);
        ADR_CTRLB: bus_rdata <= W'(ctrlb_q);
        ADR_COUNT: bus_rdata <= cnt_q;
        ADR_CMPA:  bus_rdata <= cmp_q[0];
        ADR_CMPB:  bus_rdata <= cmp_q[1];
        ADR_FLAGS: bus_rdata <= W'(flags_q);
        ADR_IRQEN: bus_rdata <= W'(irqen_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         step,
  input logic         cnt_wr,
  input logic [2:0]   clk_sel,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] cnt_q,
  input seq_e         seq,
  input logic [W-1:0] cmp_a_val,
  input logic [2:0]   flags_q,
  input logic [2:0]   irq_ack
);
  localparam logic [W-1:0] MAX   = '1;
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] MAXM1 = MAX - ONE;

  p_stopped_r1: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

  p_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(bus_wdata)));

  // R4..R7: every step moves the count by one or clears it
  p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
    step |=> ((cnt_q - $past(cnt_q)) == ONE || ($past(cnt_q) - cnt_q) == ONE ||
              cnt_q == '0));

  p_ctc_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (step && seq == SEQ_CLR_MATCH && cnt_q == cmp_a_val) |=> (cnt_q == '0));

  p_phase_turn_r7: assert property (@(posedge clk) disable iff (rst)
    (step && seq == SEQ_PHASE && cnt_q == MAX) |=> (cnt_q == MAXM1));

  p_cmp_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q == cmp_a_val) |=> flags_q[1]);

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (flags_q[0] && irq_ack[0] && !step) |=> !flags_q[0]);
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .cnt_wr(cnt_wr), .clk_sel(clk_sel),
  .bus_wdata(bus_wdata), .cnt_q(cnt_q), .seq(seq), .cmp_a_val(cmp_a_val),
  .flags_q(flags_q), .irq_ack(irq_ack)
);

// File: tb/tmr8_dual_cmp_tb.sv
module tmr8_dual_cmp_tb;
  localparam logic [2:0] A_CTRLA = 3'd0, A_CTRLB = 3'd1, A_COUNT = 3'd2,
                         A_CMPA = 3'd3, A_CMPB = 3'd4, A_FLAGS = 3'd5,
                         A_IRQEN = 3'd6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] presc_tick = '0;
  logic       ext_pin = 1'b0;
  logic [2:0] irq_ack = '0;
  logic [2:0] irq;
  logic       oc_a, oc_b, at_top, at_bottom;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [7:0] m_cnt;
  bit         m_dn;
  bit [2:0]   m_flg;
  bit         m_oc [2];
  int         m_seq;
  logic [7:0] m_cmp [2];
  logic [1:0] m_com [2];

  tmr8_dual_cmp u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
    .ext_pin(ext_pin), .irq_ack(irq_ack), .irq(irq), .oc_a(oc_a),
    .oc_b(oc_b), .at_top(at_top), .at_bottom(at_bottom)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_we = 1'b0;
    cyc();
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic tick1(input logic [2:0] ack);
    presc_tick = 4'b0001; irq_ack = ack;
    cyc();
    presc_tick = '0; irq_ack = '0;
  endtask

  // one model tick: compare, flags, count sequence and outputs
  task automatic model_tick();
    logic [7:0] c;
    bit mt [2];
    bit reinit, ovf, dn;
    c = m_cnt;
    ovf = 0;
    for (int i = 0; i < 2; i++) mt[i] = (c == m_cmp[i]);
    reinit = (m_seq == 2 && c == 8'hFF) || (m_seq == 3 && c == 8'h00);
    case (m_seq)
      1: begin
        ovf = (c == 8'hFF);
        m_cnt = (c == m_cmp[0]) ? 8'h00 : c + 8'd1;
      end
      3: begin
        dn = (c == 8'hFF) ? 1'b1 : (c == 8'h00) ? 1'b0 : m_dn;
        m_dn = dn;
        m_cnt = dn ? c - 8'd1 : c + 8'd1;
        ovf = (c == 8'h00);
      end
      default: begin
        ovf = (c == 8'hFF);
        m_cnt = c + 8'd1;
      end
    endcase
    m_flg = m_flg | {mt[1], mt[0], ovf};
    for (int i = 0; i < 2; i++) begin
      bit v;
      v = m_oc[i];
      if (m_com[i] == 2'b00) v = 0;
      else begin
        if (reinit && m_com[i] == 2'b10) v = 1;
        if (reinit && m_com[i] == 2'b11) v = 0;
        if (mt[i]) begin
          if (m_com[i] == 2'b01) v = ~v;
          else if (m_com[i] == 2'b10) v = 0;
          else v = 1;
        end
      end
      m_oc[i] = v;
    end
  endtask

  task automatic rand_cycle(input string ctag);
    bit t;
    logic [2:0] ack;
    logic [7:0] prev;
    t = ($urandom % 4) != 0;
    ack = (($urandom % 16) == 0) ? 3'($urandom % 8) : 3'b000;
    presc_tick = {3'b000, t};
    irq_ack = ack;
    bus_addr = A_COUNT;
    prev = m_cnt;
    m_flg = m_flg & ~ack;
    if (t) model_tick();
    cyc();
    chk(ctag, bus_rdata, prev);
    chk("R8 top", at_top, m_cnt == 8'hFF);
    chk("R8 bottom", at_bottom, m_cnt == 8'h00);
    chk("R12 oc_a", oc_a, m_oc[0]);
    chk("R12 oc_b", oc_b, m_oc[1]);
    chk("R9 irq flags", irq, m_flg);
  endtask

  task automatic run_mode(input int sq, input logic [2:0] wave, input int n, input string ctag);
    m_seq = sq;
    for (int i = 0; i < 2; i++) begin
      m_cmp[i] = 8'($urandom);
      m_com[i] = 2'($urandom);
      m_oc[i] = 0;
    end
    if (sq == 1 && m_cmp[0] < 8'h20) m_cmp[0] = m_cmp[0] + 8'h40;
    m_cnt = 8'($urandom);
    m_flg = '0;
    m_dn = 0;
    wr(A_CTRLB, 8'h00);
    wr(A_CTRLA, 8'h00);
    wr(A_CTRLA, {2'b00, m_com[1], m_com[0], wave[1:0]});
    wr(A_CMPA, m_cmp[0]);
    wr(A_CMPB, m_cmp[1]);
    wr(A_IRQEN, 8'h07);
    wr(A_COUNT, m_cnt);
    wr(A_FLAGS, 8'h07);
    wr(A_CTRLB, {4'b0000, wave[2], 3'b010});
    for (int k = 0; k < n; k++) rand_cycle(ctag);
    presc_tick = '0; irq_ack = '0;
    wr(A_CTRLB, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    @(negedge clk);
    idle(3);
    rst = 1'b0;

    // R13 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R13 reset read", v, 8'h00);
    end
    chk("R8 reset bottom", at_bottom, 1'b1);
    chk("R8 reset top", at_top, 1'b0);
    chk("R13 reset oc", {oc_a, oc_b}, 2'b00);
    chk("R13 reset irq", irq, 3'b000);

    // R1 stopped, every clock, tap selection
    wr(A_COUNT, 8'd10);
    presc_tick = 4'hF; idle(5); presc_tick = '0;
    rd(A_COUNT, v); chk("R1 stopped", v, 8'd10);
    wr(A_CTRLB, 8'd1); idle(4); wr(A_CTRLB, 8'd0);
    rd(A_COUNT, v); chk("R1 every clock", v, 8'd15);
    wr(A_CTRLB, 8'd4);
    presc_tick = 4'b0100; idle(3);
    presc_tick = 4'b1011; idle(4);
    presc_tick = '0;
    wr(A_CTRLB, 8'd0);
    rd(A_COUNT, v); chk("R1 tap 2 only", v, 8'd18);

    // R2 external edges
    wr(A_COUNT, 8'd0);
    wr(A_CTRLB, 8'd6);
    ext_pin = 1'b1; idle(6);
    rd(A_COUNT, v); chk("R2 falling ignores rise", v, 8'd0);
    ext_pin = 1'b0; idle(6);
    rd(A_COUNT, v); chk("R2 falling edge", v, 8'd1);
    wr(A_CTRLB, 8'd7);
    for (int p = 0; p < 3; p++) begin
      ext_pin = 1'b1; idle(4);
      ext_pin = 1'b0; idle(4);
    end
    rd(A_COUNT, v); chk("R2 rising edges", v, 8'd4);
    wr(A_CTRLB, 8'd0);

    // R3 write priority and live read
    wr(A_CTRLB, 8'd1); idle(3);
    wr(A_COUNT, 8'h40);
    rd(A_COUNT, v); chk("R3 write wins", v, 8'h40);
    rd(A_COUNT, v); chk("R3 read while running", v, 8'h41);
    wr(A_CTRLB, 8'd0);

    // R4 overflow, R10 clears, set-wins
    wr(A_IRQEN, 8'h07);
    wr(A_FLAGS, 8'h07);
    wr(A_COUNT, 8'hFE);
    wr(A_CTRLB, 8'd2);
    tick1(3'b000);
    chk("R4 no overflow before wrap", irq[0], 1'b0);
    tick1(3'b000);
    chk("R4 overflow at wrap", irq[0], 1'b1);
    wr(A_FLAGS, 8'h00);
    rd(A_FLAGS, v); chk("R10 zero write no effect", v[0], 1'b1);
    wr(A_FLAGS, 8'h01);
    rd(A_FLAGS, v); chk("R10 write one clears", v[0], 1'b0);
    wr(A_COUNT, 8'hFF);
    tick1(3'b001);
    chk("R10 set wins over ack", irq[0], 1'b1);
    irq_ack = 3'b001; cyc(); irq_ack = '0;
    chk("R10 ack clears", irq[0], 1'b0);

    // R11 enable masking
    wr(A_COUNT, 8'hFF);
    tick1(3'b000);
    wr(A_IRQEN, 8'h00);
    chk("R11 masked irq", irq, 3'b000);
    rd(A_FLAGS, v); chk("R11 flag still set", v[0], 1'b1);
    wr(A_IRQEN, 8'h01);
    chk("R11 enabled irq", irq[0], 1'b1);
    wr(A_CTRLB, 8'd0);

    // random runs per counting sequence, phase-correct last
    run_mode(0, 3'b000, 1200, "R4 normal count");
    run_mode(1, 3'b010, 1200, "R5 clear-on-match count");
    run_mode(2, 3'b011, 1200, "R6 fast count");
    run_mode(3, 3'b001, 1600, "R7 phase count");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule